// File: doc/BRIEF.md
# Interrupt Vector Redirection Unit

This block sits in the vector-fetch path of a small controller with a 16-bit byte address space. When part of the flash is locked against erasure, the default interrupt vector table at the top of memory is locked too. The unit lets firmware move interrupt vectors out of the locked area. It rewrites each interrupt-vector fetch address so that the fetch lands in a table of the same size that sits directly below the locked region. That table can be reprogrammed freely.

Redirection is enabled by an active-low option bit. It only happens when the flash is partly locked. With nothing locked, or with everything locked, addresses pass through unchanged. The two-byte reset vector at the very top of memory is never moved. The option bit, the lock boundary and the "nothing locked" flag are captured into registers while reset is asserted. After reset is released, those registers hold their values. The address path itself is combinational.

Top module: `vec_redirect`

## Requirements
- R1: While `rst_n` is low, the option inputs (`redir_off_i`, `lock_none_i`, `lock_base_i`) are loaded into internal registers. After `rst_n` goes high, later changes on those inputs have no effect on `fetch_addr_o` or `redirected_o`.
- R2: If the captured `redir_off_i` is 1, every address passes through unchanged and `redirected_o` is 0.
- R3: If the captured `lock_none_i` is 1 (nothing locked), every address passes through unchanged and `redirected_o` is 0.
- R4: If the captured `lock_base_i` is 16'h0000 (all of flash locked), every address passes through unchanged and `redirected_o` is 0.
- R5: Redirection is active when the captured values give `redir_off_i`=0, `lock_none_i`=0 and `lock_base_i`≠0. In that case, an address A in 16'hFFC0..16'hFFFD produces `fetch_addr_o` = `lock_base_i` − 16'h0040 + (A − 16'hFFC0), computed modulo 2^16, and `redirected_o` = 1.
- R6: Addresses 16'hFFFE and 16'hFFFF (the reset vector) are never redirected. They pass through unchanged with `redirected_o` = 0.
- R7: Addresses below 16'hFFC0 always pass through unchanged with `redirected_o` = 0.
- R8: With a 512-byte lock (`lock_base_i` = 16'hFE00) and redirection active, 16'hFFE0 maps to 16'hFDE0, 16'hFFC0 maps to 16'hFDC0, and 16'hFFFD maps to 16'hFDFD.
- R9: The address path is combinational. `fetch_addr_o` and `redirected_o` follow `fetch_addr_i` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the option capture registers |
| rst_n | input | 1 | Active-low reset; option inputs are captured while it is low |
| redir_off_i | input | 1 | Option bit; 0 enables redirection, 1 disables it |
| lock_none_i | input | 1 | 1 when no flash is locked |
| lock_base_i | input | 16 | Lowest locked address; 0 means all of flash is locked |
| fetch_addr_i | input | 16 | Address of the vector fetch |
| fetch_addr_o | output | 16 | Effective fetch address |
| redirected_o | output | 1 | 1 when the fetch address was rewritten |

## Verification
The bench targets the edges of the vector window: 16'hFFBF just below it, 16'hFFC0 and 16'hFFFD at its two ends, and the reset vector bytes 16'hFFFE/16'hFFFF just above it. An off-by-one window would either move the reset vector or leave the last interrupt vector in the locked region. It also covers the two degenerate lock settings, all locked and none locked, and the polarity of the option bit. A design that got any of these wrong would redirect fetches into flash that was never programmed. Finally, the option inputs are changed after reset is released. A design that kept sampling them, instead of holding them, would move vectors at run time.

// File: rtl/vec_redirect.sv
module vec_redirect #(
  parameter int AW       = 16,
  parameter int TBL_SIZE = 64,
  parameter int RST_VEC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_off_i,
  input  logic          lock_none_i,
  input  logic [AW-1:0] lock_base_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          redirected_o
);

  localparam logic [AW-1:0] TBL_LO  = AW'((1 << AW) - TBL_SIZE);
  localparam logic [AW-1:0] VEC_HI  = AW'((1 << AW) - RST_VEC - 1);
  localparam logic [AW-1:0] TBL_SZV = AW'(TBL_SIZE);

  logic          off_q;
  logic          none_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= redir_off_i;
      none_q <= lock_none_i;
      base_q <= lock_base_i;
    end
  end

  logic partial, in_win;
  assign partial      = !off_q && !none_q && (base_q != '0);
  assign in_win       = (fetch_addr_i >= TBL_LO) && (fetch_addr_i <= VEC_HI);
  assign redirected_o = partial && in_win;
  assign fetch_addr_o = redirected_o ? (base_q - TBL_SZV + (fetch_addr_i - TBL_LO))
                                     : fetch_addr_i;

  a_r1_opts_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(off_q) && $stable(none_q) && $stable(base_q)));
  a_r2_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> (!redirected_o && fetch_addr_o == fetch_addr_i));
  a_r3_none_pass: assert property (@(posedge clk) disable iff (!rst_n)
    none_q |-> (!redirected_o && fetch_addr_o == fetch_addr_i));
  a_r4_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q == '0) |-> (!redirected_o && fetch_addr_o == fetch_addr_i));
  a_r6_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr_i > VEC_HI) |-> (!redirected_o && fetch_addr_o == fetch_addr_i));
  a_r7_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr_i < TBL_LO) |-> (!redirected_o && fetch_addr_o == fetch_addr_i));

endmodule

// File: tb/vec_redirect_test.sv
module vec_redirect_test;
  logic clk = 0, rst_n = 0, off = 1, none = 1;
  logic [15:0] base = 0, addr = 0, aout;
  logic red;
  int checks = 0, fails = 0;
  logic cur_off, cur_none;
  logic [15:0] cur_base;

  always #2.5 clk = ~clk;

  vec_redirect uut (.clk(clk), .rst_n(rst_n), .redir_off_i(off), .lock_none_i(none),
    .lock_base_i(base), .fetch_addr_i(addr), .fetch_addr_o(aout), .redirected_o(red));

  function automatic logic [16:0] model(input logic o, input logic n,
                                        input logic [15:0] b, input logic [15:0] a);
    if (!o && !n && b != 0 && a >= 16'hFFC0 && a <= 16'hFFFD)
      return {1'b1, 16'(b - 16'h0040 + (a - 16'hFFC0))};
    return {1'b0, a};
  endfunction

  task automatic chk(input string req, input logic [15:0] a);
    logic [16:0] e;
    addr = a;
    #1;
    e = model(cur_off, cur_none, cur_base, a);
    checks++;
    if ({red, aout} !== e) begin
      fails++;
      $display("FAIL %s addr=%h actual=%b/%h expected=%b/%h", req, a, red, aout, e[16], e[15:0]);
    end
  endtask

  task automatic cfg(input logic o, input logic n, input logic [15:0] b);
    rst_n = 0; off = o; none = n; base = b;
    cur_off = o; cur_none = n; cur_base = b;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
  endtask

  task automatic edges(input string req);
    chk(req, 16'hFFBF); chk(req, 16'hFFC0); chk(req, 16'hFFE0);
    chk(req, 16'hFFFD); chk(req, 16'hFFFE); chk(req, 16'hFFFF); chk(req, 16'h0000);
  endtask

  task automatic rnd(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] a = 16'($urandom);
      if (i % 2 == 0) a[15:6] = 10'h3FF;
      chk(req, a);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    // R1 reset state: option bit disabled, captured during reset
    cfg(1'b1, 1'b0, 16'hFE00);
    edges("R2"); rnd("R2", 100);
    cfg(1'b0, 1'b1, 16'hFE00);
    edges("R3"); rnd("R3", 100);
    cfg(1'b0, 1'b0, 16'h0000);
    edges("R4"); rnd("R4", 100);
    cfg(1'b0, 1'b0, 16'hFE00);
    edges("R8"); edges("R6");
    chk("R9", 16'hFFC4); addr = 16'hFFC8; #0.5; checks++;
    if (aout !== 16'hFDC8) begin fails++; $display("FAIL R9 actual=%h expected=fdc8", aout); end
    // R1: change options after reset release, behaviour must not follow
    off = 1; none = 1; base = 16'h8000;
    @(negedge clk); @(negedge clk);
    edges("R1"); rnd("R1", 100);
    for (int k = 0; k < 20; k++) begin
      logic [15:0] b = 16'($urandom);
      if (k == 0) b = 16'h0010;
      cfg(1'b0, 1'b0, b);
      edges("R5"); rnd("R5", 80); rnd("R7", 20);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule